// File: doc/BRIEF.md
# Multi-Range Frequency Meter

The block measures the frequency of a conditioned digital input and reports it in hertz as a 32-bit value. It counts rising edges of the input during a gate window that is built from an external millisecond tick. At the end of each window the count is scaled to one second and latched into the output, and a one-clock strobe marks the new value. The window length follows a range selector. Auto uses 330 ms. The low-frequency range uses 1000 ms, which gives the best resolution. The high-frequency range uses 100 ms, which gives the fastest refresh.

An idle watchdog runs beside the gate. When the input has shown no rising edge for a programmable number of milliseconds, the output drops to zero at once, and every window that closes while the input stays silent also reports zero. A programmed timeout of zero is never used as given, because it would zero every reading. The block uses a fallback of 1000 ms in its place.

Top module: `freq_meter`

## Requirements
- R1: While reset is asserted and after it is released, `freq_hz` is 0 and `freq_valid` is 0 until the first result is latched.
- R2: `range_mode` code 0 selects a 330 ms window, code 1 a 1000 ms window and code 2 a 100 ms window. A window closes on the P-th `ms_tick` after it starts (P = window length), and `freq_valid` is high in the clock cycle that follows that tick. No strobe occurs in any cycle that does not follow a tick.
- R3: The latched value is N in the 1000 ms range, N*10 in the 100 ms range and floor((N*1000+165)/330) in the 330 ms range, where N is the number of rising edges counted in the window.
- R4: `range_mode` code 3 behaves exactly like code 0.
- R5: `freq_valid` is high for exactly one clock per latched result, and `freq_hz` does not change in any cycle where `freq_valid` is low.
- R6: After a rising edge, when the count of `ms_tick` pulses with no further rising edge reaches `timeout_ms`, `freq_hz` becomes 0 with a strobe. Every window that closes while the input is still idle reports 0, even if it counted edges before the timeout. A later rising edge ends the idle state.
- R7: A `timeout_ms` of 0 is replaced by 1000.
- R8: A change of the range selector restarts the gate window and discards the edges counted so far. The first result after the change covers the new window length only.
- R9: Only rising edges of `sig_in`, after a two-flop synchronizer, are counted. A high pulse counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-clock pulse once per millisecond |
| sig_in | input | 1 | Conditioned input signal, asynchronous to clk |
| range_mode | input | 2 | Range select: 0 auto, 1 low frequency, 2 high frequency, 3 as auto |
| timeout_ms | input | 16 | Idle timeout in ms; 0 selects 1000 |
| freq_hz | output | 32 | Last measured frequency in Hz |
| freq_valid | output | 1 | One-clock strobe when `freq_hz` is updated |

## Verification
The hardest case to reach is the one where both timers interact: a window that collected edges, then went idle long enough to expire before it closed. Checking it means placing edges and ticks so the expiry falls on a known tick well before the window ends. The bench drives the tick itself and builds every millisecond as a fixed slot with an optional pulse in the middle. This makes the tick on which each window closes, and each idle tick that follows the last edge, exactly predictable. Short timeouts such as 7 ms then place the expiry on a chosen slot, and the zero-timeout fallback is exposed by a lone edge one slot into a 1000 ms window.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    RANGE_AUTO = 2'd0,
    RANGE_LOW  = 2'd1,
    RANGE_HIGH = 2'd2,
    RANGE_RSVD = 2'd3
  } range_e;
endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  // shift chain toward the MSB
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], sig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer
  import fm_pkg::*;
#(
  parameter int unsigned AUTO_MS = 330,
  parameter int unsigned LOW_MS  = 1000,
  parameter int unsigned HIGH_MS = 100,
  parameter int unsigned GW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  range_e        mode,
  output logic          gate_end,
  output logic [GW-1:0] elapsed
);
  logic [GW-1:0] cnt_q;
  logic [GW-1:0] cnt_d;
  logic [GW-1:0] last_idx;
  logic          at_last;
  logic          cnt_en;

  always_comb begin
    case (mode)
      RANGE_LOW:  last_idx = GW'(LOW_MS - 1);
      RANGE_HIGH: last_idx = GW'(HIGH_MS - 1);
      default:    last_idx = GW'(AUTO_MS - 1);
    endcase
  end

  always_comb begin
    at_last  = (cnt_q >= last_idx);
    gate_end = tick & at_last & ~restart;
    cnt_en   = restart | tick;
    if (restart || at_last) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign elapsed = cnt_q;
endmodule

// File: rtl/fm_idle_watch.sv
module fm_idle_watch #(
  parameter int unsigned TO_W       = 16,
  parameter int unsigned TO_DEFAULT = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            activity,
  input  logic [TO_W-1:0] timeout_cfg,
  output logic            expire,
  output logic            idle
);
  logic [TO_W-1:0] limit;
  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] cnt_d;
  logic            idle_q;
  logic            idle_d;
  logic            cnt_en;
  logic [TO_W:0]   cnt_inc;

  always_comb begin
    limit   = (timeout_cfg == '0) ? TO_W'(TO_DEFAULT) : timeout_cfg;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    expire  = tick & ~activity & ~idle_q & (cnt_inc >= {1'b0, limit});
    cnt_en  = activity | (tick & ~idle_q);
    cnt_d   = activity ? '0 : cnt_inc[TO_W-1:0];
    if (activity)    idle_d = 1'b0;
    else if (expire) idle_d = 1'b1;
    else             idle_d = idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      idle_q <= idle_d;
    end
  end

  assign idle = idle_q;
endmodule

// File: rtl/fm_scaler.sv
module fm_scaler
  import fm_pkg::*;
#(
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned OUT_W    = 32,
  parameter int unsigned MS_PER_S = 1000,
  parameter int unsigned AUTO_MS  = 330,
  parameter int unsigned LOW_MS   = 1000,
  parameter int unsigned HIGH_MS  = 100
) (
  input  logic [CNT_W-1:0] count,
  input  range_e           mode,
  output logic [OUT_W-1:0] hz
);
  localparam int unsigned PW = CNT_W + $clog2(MS_PER_S + 1) + 1;

  logic [OUT_W-1:0] res [3];

  // one constant-divisor path per range, index = range code
  for (genvar g = 0; g < 3; g++) begin : g_rng
    localparam int unsigned PER = (g == 0) ? AUTO_MS : ((g == 1) ? LOW_MS : HIGH_MS);
    logic [PW-1:0] num;
    logic [PW-1:0] quo;
    assign num    = PW'(count) * PW'(MS_PER_S) + PW'(PER / 2);
    assign quo    = num / PW'(PER);
    assign res[g] = OUT_W'(quo);
  end

  always_comb begin
    case (mode)
      RANGE_LOW:  hz = res[1];
      RANGE_HIGH: hz = res[2];
      default:    hz = res[0];
    endcase
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned OUT_W       = 32,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned TO_DEFAULT  = 1000,
  parameter int unsigned AUTO_MS     = 330,
  parameter int unsigned LOW_MS      = 1000,
  parameter int unsigned HIGH_MS     = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             sig_in,
  input  logic [1:0]       range_mode,
  input  logic [TO_W-1:0]  timeout_ms,
  output logic [OUT_W-1:0] freq_hz,
  output logic             freq_valid
);
  localparam int unsigned MAX_AL = (AUTO_MS > LOW_MS) ? AUTO_MS : LOW_MS;
  localparam int unsigned MAX_MS = (MAX_AL > HIGH_MS) ? MAX_AL : HIGH_MS;
  localparam int unsigned GW     = $clog2(MAX_MS + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // range selection
  range_e mode_eff;
  range_e mode_q;
  logic   restart;

  always_comb begin
    mode_eff = range_e'(range_mode);
    if (mode_eff == RANGE_RSVD) mode_eff = RANGE_AUTO;
    restart = (mode_eff != mode_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mode_q <= RANGE_AUTO;
    else if (restart) mode_q <= mode_eff;
  end

  // sub-blocks
  logic             rise;
  logic             gate_end;
  logic [GW-1:0]    gate_elapsed;
  logic             idle_expire;
  logic             idle_now;
  logic [CNT_W-1:0] edge_cnt_q;
  logic [CNT_W-1:0] edge_cnt_d;
  logic [OUT_W-1:0] scaled_hz;

  fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sig_in (sig_in),
    .rise   (rise)
  );

  fm_gate_timer #(
    .AUTO_MS (AUTO_MS),
    .LOW_MS  (LOW_MS),
    .HIGH_MS (HIGH_MS),
    .GW      (GW)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (ms_tick),
    .restart  (restart),
    .mode     (mode_q),
    .gate_end (gate_end),
    .elapsed  (gate_elapsed)
  );

  fm_idle_watch #(
    .TO_W       (TO_W),
    .TO_DEFAULT (TO_DEFAULT)
  ) u_idle (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick        (ms_tick),
    .activity    (rise),
    .timeout_cfg (timeout_ms),
    .expire      (idle_expire),
    .idle        (idle_now)
  );

  fm_scaler #(
    .CNT_W    (CNT_W),
    .OUT_W    (OUT_W),
    .MS_PER_S (1000),
    .AUTO_MS  (AUTO_MS),
    .LOW_MS   (LOW_MS),
    .HIGH_MS  (HIGH_MS)
  ) u_scale (
    .count (edge_cnt_q),
    .mode  (mode_q),
    .hz    (scaled_hz)
  );

  // edge counter: an edge in the closing cycle belongs to the next window
  always_comb begin
    if (restart || gate_end) edge_cnt_d = {{(CNT_W-1){1'b0}}, rise};
    else if (rise && !(&edge_cnt_q)) edge_cnt_d = edge_cnt_q + 1'b1;
    else edge_cnt_d = edge_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) edge_cnt_q <= '0;
    else            edge_cnt_q <= edge_cnt_d;
  end

  // result register
  logic             upd_en;
  logic [OUT_W-1:0] hz_d;

  always_comb begin
    upd_en = idle_expire | gate_end;
    if (idle_expire || idle_now) hz_d = '0;
    else                         hz_d = scaled_hz;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      freq_hz    <= '0;
      freq_valid <= 1'b0;
    end else begin
      freq_valid <= upd_en;
      if (upd_en) freq_hz <= hz_d;
    end
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int unsigned OUT_W   = 32,
  parameter int unsigned GW      = 10,
  parameter int unsigned AUTO_MS = 330,
  parameter int unsigned LOW_MS  = 1000,
  parameter int unsigned HIGH_MS = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic [OUT_W-1:0] freq_hz,
  input logic             freq_valid,
  input logic             expire,
  input logic [1:0]       mode_q,
  input logic [GW-1:0]    elapsed
);
  logic [GW-1:0] win_len;

  always_comb begin
    case (mode_q)
      2'd1:    win_len = GW'(LOW_MS);
      2'd2:    win_len = GW'(HIGH_MS);
      default: win_len = GW'(AUTO_MS);
    endcase
  end

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_valid |-> $stable(freq_hz));

  assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    freq_valid |-> $past(ms_tick));

  assert_zero_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (freq_valid && freq_hz == '0));

  assert_high_range_decade_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && $past(mode_q) == 2'd2) |-> (freq_hz % OUT_W'(10)) == '0);

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed < win_len);
endmodule

bind freq_meter fm_checker #(
  .OUT_W   (OUT_W),
  .GW      (GW),
  .AUTO_MS (AUTO_MS),
  .LOW_MS  (LOW_MS),
  .HIGH_MS (HIGH_MS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ms_tick    (ms_tick),
  .freq_hz    (freq_hz),
  .freq_valid (freq_valid),
  .expire     (idle_expire),
  .mode_q     (mode_q),
  .elapsed    (gate_elapsed)
);

// File: tb/freq_meter_test.sv
module freq_meter_test;
  logic        clk;
  logic        rst_n;
  logic        ms_tick;
  logic        sig_in;
  logic [1:0]  range_mode;
  logic [15:0] timeout_ms;
  logic [31:0] freq_hz;
  logic        freq_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int strobes  = 0;
  logic [31:0] last_hz = '0;
  bit done = 0;

  freq_meter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .sig_in     (sig_in),
    .range_mode (range_mode),
    .timeout_ms (timeout_ms),
    .freq_hz    (freq_hz),
    .freq_valid (freq_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus table: range code, timeout, edges in first window, expected Hz
  localparam int NV = 8;
  localparam int V_MODE  [NV] = '{1,    2,    0,    0,    3,    2,    0,    2};
  localparam int V_TO    [NV] = '{1000, 1000, 1000, 500,  1000, 1000, 1000, 0};
  localparam int V_EDGES [NV] = '{7,    37,   33,   100,  1,    100,  330,  0};
  localparam int V_EXP   [NV] = '{7,    370,  100,  303,  3,    1000, 1000, 0};

  always @(negedge clk) begin
    if (rst_n && freq_valid) begin
      strobes = strobes + 1;
      last_hz = freq_hz;
    end
  end

  function automatic int win_of(input int m);
    if (m == 1)      return 1000;
    else if (m == 2) return 100;
    else             return 330;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic do_reset(input int m, input int t, input bit chk);
    @(negedge clk);
    rst_n      = 1'b0;
    sig_in     = 1'b0;
    ms_tick    = 1'b0;
    range_mode = 2'(m);
    timeout_ms = 16'(t);
    repeat (3) @(negedge clk);
    if (chk) begin
      check("R1", "freq_hz in reset", freq_hz, 32'd0);
      check("R1", "freq_valid in reset", {31'd0, freq_valid}, 32'd0);
    end
    strobes = 0;
    rst_n   = 1'b1;
    repeat (4) @(negedge clk);
    if (chk) begin
      check("R1", "freq_hz after release", freq_hz, 32'd0);
      check("R1", "no strobe after release", strobes, 32'd0);
    end
  endtask

  // one millisecond slot: optional 2-cycle pulse, then a tick at the end
  task automatic run_slots(input int total, input int pulsed);
    for (int s = 0; s < total; s++) begin
      @(negedge clk);
      ms_tick = 1'b0;
      sig_in  = (s < pulsed);
      repeat (2) @(negedge clk);
      sig_in = 1'b0;
      repeat (4) @(negedge clk);
      ms_tick = 1'b1;
    end
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", 200000);
      report();
    end
  end

  initial begin
    rst_n      = 1'b0;
    sig_in     = 1'b0;
    ms_tick    = 1'b0;
    range_mode = 2'd0;
    timeout_ms = 16'd1000;
    do_reset(0, 1000, 1'b1);

    // table walk; each 2-cycle high pulse is one rising edge (R9)
    for (int i = 0; i < NV; i++) begin
      int p;
      int first;
      string req;
      p     = win_of(V_MODE[i]);
      first = (V_EDGES[i] > p - 1) ? p - 1 : V_EDGES[i];
      req   = (V_MODE[i] == 3) ? "R4" : "R3 R9";
      do_reset(V_MODE[i], V_TO[i], 1'b0);
      run_slots(p - 1, first);
      @(negedge clk);
      check("R2", "no strobe before window end", strobes, 32'd0);
      run_slots(1, V_EDGES[i] - first);
      @(negedge clk);
      check("R2 R5", "one strobe at window end", strobes, 32'd1);
      check(req, "window result", last_hz, 32'(V_EXP[i]));
    end

    // R6: short timeout after a full high-range window
    do_reset(2, 7, 1'b0);
    run_slots(100, 100);
    @(negedge clk);
    check("R6", "result before idle", last_hz, 32'd1000);
    run_slots(5, 0);
    @(negedge clk);
    check("R6", "no early timeout", strobes, 32'd1);
    run_slots(1, 0);
    @(negedge clk);
    check("R6", "timeout strobe", strobes, 32'd2);
    check("R6", "timeout value", last_hz, 32'd0);
    run_slots(94, 0);
    @(negedge clk);
    check("R6", "idle window strobe", strobes, 32'd3);
    check("R6", "idle window value", last_hz, 32'd0);
    run_slots(100, 100);
    @(negedge clk);
    check("R6", "recovery after edges", last_hz, 32'd1000);

    // R6: edges early in a long window, then expiry before it closes
    do_reset(1, 7, 1'b0);
    run_slots(10, 10);
    run_slots(6, 0);
    @(negedge clk);
    check("R6", "expiry inside low window", strobes, 32'd1);
    run_slots(984, 0);
    @(negedge clk);
    check("R6", "window after expiry", strobes, 32'd2);
    check("R6", "counted edges discarded", last_hz, 32'd0);

    // R7: zero timeout means 1000 ms
    do_reset(1, 0, 1'b0);
    run_slots(1, 0);
    run_slots(1, 1);
    run_slots(998, 0);
    @(negedge clk);
    check("R7", "single strobe at window end", strobes, 32'd1);
    check("R7", "edge kept with zero timeout", last_hz, 32'd1);
    run_slots(1, 0);
    @(negedge clk);
    check("R7", "expiry after 1000 ticks", strobes, 32'd2);
    check("R7", "expiry value", last_hz, 32'd0);

    // R8: range change restarts the window
    do_reset(1, 1000, 1'b0);
    run_slots(50, 50);
    @(negedge clk);
    range_mode = 2'd2;
    run_slots(99, 99);
    @(negedge clk);
    check("R8", "no strobe before new window end", strobes, 32'd0);
    run_slots(1, 1);
    @(negedge clk);
    check("R8", "strobe after restart", strobes, 32'd1);
    check("R8", "old edges discarded", last_hz, 32'd1000);

    done = 1;
    report();
  end
endmodule